// File: doc/BRIEF.md
# Load/Store Register-Offset Shifter

This block takes the register offset of a load or store and applies the optional shift that the instruction asks for. It supports five shift kinds: logical left, logical right, arithmetic right, rotate right, and a one-bit rotate that brings the carry flag in at the top. It also decides whether the requested shift is allowed. That depends on the range of the shift amount, on the kind of transfer, and on which instruction encoding issued the access.

The block is purely combinational, and it sits between operand read and address generation. When the request is not allowed, the block raises `bad_shift` and passes the offset through unchanged. The decode or exception logic downstream then decides what to do. Flag updates and the base-plus-offset arithmetic belong to neighbouring blocks.

Top module: `ls_offset_shifter`

## Requirements
- R1: With `sh_kind` = 0 (logical left), amounts 0 to 31 are legal and give `ofs_in` shifted left with zeros entering at bit 0. Logical left by 0 means "no shift": it is legal for every transfer kind and either encoding, and it returns `ofs_in` with `bad_shift` = 0.
- R2: With `sh_kind` = 1 (logical right), amounts 1 to 32 are legal and give a zero-filled right shift. An amount of 32 gives all zeros.
- R3: With `sh_kind` = 2 (arithmetic right), amounts 1 to 32 are legal and give a right shift filled with bit 31. An amount of 32 copies bit 31 into every bit.
- R4: With `sh_kind` = 3 (rotate right), amounts 1 to 31 are legal. Bits leaving at bit 0 re-enter at bit 31.
- R5: With `sh_kind` = 4 (extended rotate), the result is `{carry_in, ofs_in[31:1]}`, and `sh_amt` is ignored.
- R6: An amount outside the legal range of its kind raises `bad_shift`. The illegal amounts are: logical left 32 or more; logical or arithmetic right 0 or 33 and above; rotate right 0 or 32 and above. Shift codes 5, 6 and 7 are always illegal.
- R7: Any shift other than logical left by 0 raises `bad_shift` when `alt_enc` = 1 (compact encoding), or when `xfer_kind` is anything but 0 (word) or 1 (unsigned byte). The other transfer codes are 2 signed byte, 3 unsigned halfword, 4 signed halfword and 5 doubleword; 6 and 7 are reserved.
- R8: Whenever `bad_shift` = 1, `ofs_out` equals `ofs_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ofs_in | input | 32 | Register offset before shifting |
| sh_kind | input | 3 | Shift kind code (0 left, 1 logical right, 2 arithmetic right, 3 rotate, 4 extended rotate) |
| sh_amt | input | 6 | Shift amount |
| carry_in | input | 1 | Carry flag, used by the extended rotate |
| xfer_kind | input | 3 | Transfer kind code |
| alt_enc | input | 1 | 1 when the access comes from the compact encoding |
| ofs_out | output | 32 | Shifted offset, or `ofs_in` when illegal |
| bad_shift | output | 1 | Requested shift is not allowed |

## Verification
Directed vectors cover each kind at the edges of its legal range and one step outside it. These separate the two right shifts, which accept 32, from left shift and rotate, which stop at 31. A 32-bit shift is applied to a negative and to a positive offset, which tells sign fill apart from zero fill. The extended rotate is tried with both carry values and with varying amounts, showing that carry reaches bit 31 and that the amount has no effect. Random sweeps over every transfer kind and both encodings, compared with a bitwise reference model, separate gating by transfer and encoding from gating by amount, and confirm pass-through on every rejection.

// File: rtl/ls_offset_shifter.sv
`timescale 1ns/1ps
module ls_offset_shifter #(
  parameter int WIDTH = 32,
  localparam int AMT_W = $clog2(WIDTH) + 1
) (
  input  logic [WIDTH-1:0] ofs_in,
  input  logic [2:0]       sh_kind,
  input  logic [AMT_W-1:0] sh_amt,
  input  logic             carry_in,
  input  logic [2:0]       xfer_kind,
  input  logic             alt_enc,
  output logic [WIDTH-1:0] ofs_out,
  output logic             bad_shift
);
  localparam logic [2:0] K_LSL = 3'd0, K_LSR = 3'd1, K_ASR = 3'd2, K_ROR = 3'd3, K_RRX = 3'd4;
  localparam logic [2:0] X_WORD = 3'd0, X_UBYTE = 3'd1;
  localparam logic [AMT_W-1:0] AMT_FULL = AMT_W'(WIDTH);
  localparam logic [AMT_W-1:0] AMT_TOP  = AMT_W'(WIDTH - 1);

  logic             no_shift, amt_ok, kind_ok;
  logic [WIDTH-1:0] shifted;
  logic [2*WIDTH-1:0] rot_pair;

  assign no_shift = (sh_kind == K_LSL) && (sh_amt == '0);
  assign kind_ok  = !alt_enc && (xfer_kind == X_WORD || xfer_kind == X_UBYTE);

  always_comb begin
    unique case (sh_kind)
      K_LSL:        amt_ok = sh_amt <= AMT_TOP;
      K_LSR, K_ASR: amt_ok = (sh_amt != '0) && (sh_amt <= AMT_FULL);
      K_ROR:        amt_ok = (sh_amt != '0) && (sh_amt <= AMT_TOP);
      K_RRX:        amt_ok = 1'b1;
      default:      amt_ok = 1'b0;
    endcase
  end

  assign rot_pair = {ofs_in, ofs_in} >> sh_amt;

  always_comb begin
    unique case (sh_kind)
      K_LSL:   shifted = ofs_in << sh_amt;
      K_LSR:   shifted = (sh_amt >= AMT_FULL) ? '0 : ofs_in >> sh_amt;
      K_ASR:   shifted = (sh_amt >= AMT_FULL) ? {WIDTH{ofs_in[WIDTH-1]}}
                                              : WIDTH'($signed(ofs_in) >>> sh_amt);
      K_ROR:   shifted = rot_pair[WIDTH-1:0];
      K_RRX:   shifted = {carry_in, ofs_in[WIDTH-1:1]};
      default: shifted = ofs_in;
    endcase
  end

  assign bad_shift = !no_shift && !(amt_ok && kind_ok);
  assign ofs_out   = bad_shift ? ofs_in : shifted;
endmodule

// File: rtl/ls_offset_shifter_chk.sv
`timescale 1ns/1ps
module ls_offset_shifter_chk #(
  parameter int WIDTH = 32,
  localparam int AMT_W = $clog2(WIDTH) + 1
) (
  input logic [WIDTH-1:0] ofs_in,
  input logic [2:0]       sh_kind,
  input logic [AMT_W-1:0] sh_amt,
  input logic             carry_in,
  input logic [2:0]       xfer_kind,
  input logic             alt_enc,
  input logic [WIDTH-1:0] ofs_out,
  input logic             bad_shift
);
  always_comb begin
    a_r1_zero_left_is_identity: assert (!(sh_kind == 3'd0 && sh_amt == '0) ||
                                        (!bad_shift && ofs_out == ofs_in));
    a_r2_full_right_clears: assert (bad_shift || !(sh_kind == 3'd1 && sh_amt == AMT_W'(WIDTH)) ||
                                    ofs_out == '0);
    a_r3_full_arith_sign: assert (bad_shift || !(sh_kind == 3'd2 && sh_amt == AMT_W'(WIDTH)) ||
                                  ofs_out == {WIDTH{ofs_in[WIDTH-1]}});
    a_r5_extend_takes_carry: assert (bad_shift || sh_kind != 3'd4 ||
                                     (ofs_out[WIDTH-1] == carry_in &&
                                      ofs_out[WIDTH-2:0] == ofs_in[WIDTH-1:1]));
    a_r6_bad_code: assert (sh_kind < 3'd5 || bad_shift);
    a_r7_gated: assert (!(alt_enc || xfer_kind > 3'd1) ||
                        (sh_kind == 3'd0 && sh_amt == '0) || bad_shift);
    a_r8_pass_through: assert (!bad_shift || ofs_out == ofs_in);
  end
endmodule

bind ls_offset_shifter ls_offset_shifter_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/test_ls_offset_shifter.sv
`timescale 1ns/1ps
module test_ls_offset_shifter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ofs_in = '0;
  logic [2:0]  sh_kind = '0;
  logic [5:0]  sh_amt = '0;
  logic        carry_in = 1'b0;
  logic [2:0]  xfer_kind = '0;
  logic        alt_enc = 1'b0;
  logic [31:0] ofs_out;
  logic        bad_shift;
  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  ls_offset_shifter i_ls_offset_shifter (.*);

  function automatic logic [32:0] model(logic [31:0] v, int k, int a, bit c, int x, bit alt);
    bit legal;
    logic [31:0] r;
    if (k == 0 && a == 0) return {1'b0, v};
    case (k)
      0:       legal = a <= 31;
      1, 2:    legal = a >= 1 && a <= 32;
      3:       legal = a >= 1 && a <= 31;
      4:       legal = 1;
      default: legal = 0;
    endcase
    if (alt || !(x == 0 || x == 1)) legal = 0;
    if (!legal) return {1'b1, v};
    for (int i = 0; i < 32; i++) begin
      case (k)
        0: r[i] = (i - a >= 0) ? v[i-a] : 1'b0;
        1: r[i] = (i + a < 32) ? v[i+a] : 1'b0;
        2: r[i] = (i + a < 32) ? v[i+a] : v[31];
        3: r[i] = v[(i+a)%32];
        default: r[i] = (i == 31) ? c : v[i+1];
      endcase
    end
    return {1'b0, r};
  endfunction

  task automatic apply(input string tag, input logic [31:0] v, input int k, input int a,
                       input bit c, input int x, input bit alt);
    logic [32:0] exp;
    @(negedge clk);
    ofs_in = v; sh_kind = 3'(k); sh_amt = 6'(a); carry_in = c; xfer_kind = 3'(x); alt_enc = alt;
    exp = model(v, k, a, c, x, alt);
    #2;
    n_run++;
    if (bad_shift !== exp[32] || ofs_out !== exp[31:0]) begin
      n_fail++;
      $display("FAIL %s: kind=%0d amt=%0d xfer=%0d alt=%0b got bad=%0b out=%h expected bad=%0b out=%h",
               tag, k, a, x, alt, bad_shift, ofs_out, exp[32], exp[31:0]);
    end
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    apply("R1 reset-state idle", 32'h0, 0, 0, 0, 0, 0);
    apply("R1 left 4", 32'h8000_00F1, 0, 4, 0, 0, 0);
    apply("R1 left 31", 32'h0000_0003, 0, 31, 0, 1, 0);
    apply("R1 no-shift in compact mode", 32'hDEAD_BEEF, 0, 0, 0, 5, 1);
    apply("R2 right 1", 32'h8000_0001, 1, 1, 0, 0, 0);
    apply("R2 right 32", 32'hFFFF_FFFF, 1, 32, 0, 0, 0);
    apply("R3 arith 32 negative", 32'h8000_0000, 2, 32, 0, 0, 0);
    apply("R3 arith 32 positive", 32'h7FFF_FFFF, 2, 32, 0, 1, 0);
    apply("R3 arith 5", 32'hF000_0010, 2, 5, 0, 0, 0);
    apply("R4 rotate 8", 32'h1234_5678, 3, 8, 0, 0, 0);
    apply("R4 rotate 31", 32'h8000_0001, 3, 31, 0, 0, 0);
    apply("R5 extend carry 1", 32'h0000_0003, 4, 0, 1, 0, 0);
    apply("R5 extend carry 0 amt ignored", 32'hFFFF_FFFF, 4, 17, 0, 1, 0);
    apply("R6 left 32", 32'hA5A5_A5A5, 0, 32, 0, 0, 0);
    apply("R6 right 0", 32'hA5A5_A5A5, 1, 0, 0, 0, 0);
    apply("R6 arith 33", 32'hA5A5_A5A5, 2, 33, 0, 0, 0);
    apply("R6 rotate 32", 32'hA5A5_A5A5, 3, 32, 0, 0, 0);
    apply("R6 rotate 0", 32'hA5A5_A5A5, 3, 0, 0, 0, 0);
    apply("R6 code 6", 32'hA5A5_A5A5, 6, 3, 0, 0, 0);
    apply("R7 compact encoding", 32'h0F0F_0F0F, 0, 2, 0, 0, 1);
    for (int x = 2; x < 8; x++) apply("R7 transfer kind gated", 32'h0F0F_0F0F, 1, 4, 0, x, 0);
    apply("R8 pass-through on signed half", 32'h1357_9BDF, 4, 0, 1, 4, 0);
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] v = $urandom;
      int k = $urandom_range(0, 7);
      int a = $urandom_range(0, 63);
      int x = ($urandom_range(0, 3) == 0) ? $urandom_range(2, 7) : $urandom_range(0, 1);
      bit alt = ($urandom_range(0, 5) == 0);
      apply("R1-kind sweep R2 R3 R4 R5 R6 R7 R8", v, k, a, bit'($urandom), x, alt);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule